// File: doc/BRIEF.md
# Reset Boot Mode Sequencer

This block decides how a processor core comes out of reset. While the active-low reset is held, it watches three strap pins. On the first clock after reset is released it freezes them. The straps choose three things: the memory configuration (full or host), whether an automatic boot takes place, and which DMA path supplies the boot image.

The block then keeps the core on hold until the chosen boot condition is met.

- **Byte-DMA boot:** the block itself reads bytes from a byte-wide memory port. It packs each group of three bytes into one 24-bit word, most significant byte first, and writes the words to program memory addresses 0 upward. After the last of the boot words is written, the core is released.
- **Host-DMA boot:** the block only watches host writes into program memory. Writes to any other address are allowed and have no effect. The first write to address 0 releases the core.
- **No automatic boot:** the core is released at once and starts from external address 0.

The DMA engines, the host bus and the memory arrays are outside the block and appear only as plain ports.

Top module: `boot_seq_top`

## Requirements
- R1: The straps are captured at every clock edge while `rst_ni` is low, and at the first edge after its release. Strap changes after that edge have no effect on any output until the next reset.
- R2: `mem_host_o` equals the captured value of `strap_mem_i` (0 = full memory, 1 = host memory).
- R3: `run_o` is 0 during reset and through the whole boot wait.
- R4: In byte-DMA boot (`strap_noboot_i`=0, `strap_src_i`=0), byte addresses 0 to 3·`BOOT_WORDS`−1 are requested in cycles 0 to 3·`BOOT_WORDS`−1. Cycle 0 is the first cycle after release. One byte is requested per cycle, and read data is expected one cycle after its request.
- R5: Program word w (0 ≤ w < `BOOT_WORDS`) is written to `pm_addr_o`=w in cycle 3w+4, with `pm_wdata_o` = {byte 3w, byte 3w+1, byte 3w+2}.
- R6: In byte-DMA boot, `boot_done_o` is high only in cycle 3·`BOOT_WORDS`+1, the cycle of the final word write.
- R7: In host-DMA boot (`strap_noboot_i`=0, `strap_src_i`=1), host writes to nonzero addresses do not release the core. `boot_done_o` is high in the cycle of the first host write to address 0.
- R8: With `strap_noboot_i`=1, `boot_done_o` is high in cycle 0, and no byte read or program write is made.
- R9: `run_o` rises in the cycle after `boot_done_o` and then stays high until reset. `boot_done_o` pulses once per boot, and host writes after release do not raise it again.
- R10: `bm_req_o` stays low outside byte-DMA boot and after the last byte is requested. Outside byte-DMA boot, `pm_we_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| strap_mem_i | input | 1 | Memory configuration strap, 1 = host |
| strap_noboot_i | input | 1 | 1 = no automatic boot |
| strap_src_i | input | 1 | Boot source, 0 = byte DMA, 1 = host DMA |
| bm_req_o | output | 1 | Byte memory read request |
| bm_addr_o | output | BM_AW | Byte memory address |
| bm_rdata_i | input | 8 | Byte read data, valid one cycle after request |
| pm_we_o | output | 1 | Program memory write strobe |
| pm_addr_o | output | PM_AW | Program memory write address |
| pm_wdata_o | output | PM_DW | Program memory write data |
| host_we_i | input | 1 | Snooped host write into program memory |
| host_addr_i | input | PM_AW | Address of the snooped host write |
| mem_host_o | output | 1 | Captured memory configuration |
| boot_done_o | output | 1 | One-cycle pulse when the release condition is met |
| run_o | output | 1 | Core run (1) or hold (0) |

## Verification
Every result is counted in cycles from the first clock edge after reset release, which is cycle 0.

- Byte requests appear in the same cycle as their index.
- Each program word is written three cycles after the previous one, the first in cycle 4.
- `boot_done_o` coincides with the release event: the last word write, the host write to address 0, or cycle 0 without auto boot.
- `run_o` follows exactly one cycle later.

The bench drives inputs one nanosecond after a rising edge and samples at the falling edge. Each sample therefore sees one whole cycle's combinational result and the registers updated at that cycle's opening edge. The bench compares against cycle numbers computed from these formulas, for all eight strap settings.

// File: rtl/boot_seq_pkg.sv
package boot_seq_pkg;
  typedef struct packed {
    logic mem_host;
    logic no_auto;
    logic src_host;
  } boot_mode_t;
endpackage

// File: rtl/boot_strap_latch.sv
module boot_strap_latch
  import boot_seq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       strap_mem_i,
  input  logic       strap_noboot_i,
  input  logic       strap_src_i,
  output boot_mode_t mode_o,
  output logic       active_o
);
  logic       hold_q;
  boot_mode_t mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hold_q <= 1'b1;
    else         hold_q <= 1'b0;
  end

  // capture window: all reset edges plus the first edge after release
  always_ff @(posedge clk_i) begin
    if (hold_q) mode_q <= '{mem_host: strap_mem_i, no_auto: strap_noboot_i, src_host: strap_src_i};
  end

  assign mode_o   = mode_q;
  assign active_o = ~hold_q;
endmodule

// File: rtl/boot_byte_loader.sv
module boot_byte_loader #(
  parameter int BOOT_WORDS = 32,
  parameter int PM_AW      = 14,
  parameter int PM_DW      = 24,
  parameter int BM_AW      = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  output logic             bm_req_o,
  output logic [BM_AW-1:0] bm_addr_o,
  input  logic [7:0]       bm_rdata_i,
  output logic             pm_we_o,
  output logic [PM_AW-1:0] pm_addr_o,
  output logic [PM_DW-1:0] pm_wdata_o,
  output logic             last_o
);
  localparam int BPW    = PM_DW / 8;
  localparam int BYTES  = BPW * BOOT_WORDS;
  localparam int CNT_W  = $clog2(BYTES + 1);
  localparam int LANE_W = (BPW > 1) ? $clog2(BPW) : 1;
  localparam int ACC_W  = PM_DW - 8;

  logic [CNT_W-1:0]  issue_q;
  logic              pend_q;
  logic [LANE_W-1:0] lane_q;
  logic [ACC_W-1:0]  acc_q;
  logic [PM_AW-1:0]  word_q;
  logic              we_q, last_q;
  logic [PM_AW-1:0]  waddr_q;
  logic [PM_DW-1:0]  wdata_q;

  assign bm_req_o  = en_i && (issue_q < CNT_W'(BYTES));
  assign bm_addr_o = BM_AW'(issue_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      issue_q <= '0;
      pend_q  <= 1'b0;
      lane_q  <= '0;
      acc_q   <= '0;
      word_q  <= '0;
      we_q    <= 1'b0;
      last_q  <= 1'b0;
      waddr_q <= '0;
      wdata_q <= '0;
    end else begin
      we_q   <= 1'b0;
      last_q <= 1'b0;
      pend_q <= bm_req_o;
      if (bm_req_o) issue_q <= issue_q + 1'b1;
      if (pend_q) begin
        if (lane_q == LANE_W'(BPW - 1)) begin
          we_q    <= 1'b1;
          waddr_q <= word_q;
          wdata_q <= {acc_q, bm_rdata_i};
          last_q  <= (word_q == PM_AW'(BOOT_WORDS - 1));
          word_q  <= word_q + 1'b1;
          lane_q  <= '0;
        end else begin
          acc_q  <= {acc_q[ACC_W-9:0], bm_rdata_i};
          lane_q <= lane_q + 1'b1;
        end
      end
    end
  end

  assign pm_we_o    = we_q;
  assign pm_addr_o  = waddr_q;
  assign pm_wdata_o = wdata_q;
  assign last_o     = last_q;
endmodule

// File: rtl/boot_host_watch.sv
module boot_host_watch #(
  parameter int PM_AW = 14
) (
  input  logic             en_i,
  input  logic             host_we_i,
  input  logic [PM_AW-1:0] host_addr_i,
  output logic             release_o
);
  assign release_o = en_i && host_we_i && (host_addr_i == '0);
endmodule

// File: rtl/boot_seq_top.sv
module boot_seq_top
  import boot_seq_pkg::*;
#(
  parameter int BOOT_WORDS = 32,
  parameter int PM_AW      = 14,
  parameter int PM_DW      = 24,
  parameter int BM_AW      = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             strap_mem_i,
  input  logic             strap_noboot_i,
  input  logic             strap_src_i,
  output logic             bm_req_o,
  output logic [BM_AW-1:0] bm_addr_o,
  input  logic [7:0]       bm_rdata_i,
  output logic             pm_we_o,
  output logic [PM_AW-1:0] pm_addr_o,
  output logic [PM_DW-1:0] pm_wdata_o,
  input  logic             host_we_i,
  input  logic [PM_AW-1:0] host_addr_i,
  output logic             mem_host_o,
  output logic             boot_done_o,
  output logic             run_o
);
  boot_mode_t mode;
  logic       active, byte_en, host_en, byte_last, host_rel, release_c, run_q;

  boot_strap_latch u_strap (
    .clk_i, .rst_ni, .strap_mem_i, .strap_noboot_i, .strap_src_i,
    .mode_o(mode), .active_o(active)
  );

  assign byte_en = active && !mode.no_auto && !mode.src_host;
  assign host_en = active && !mode.no_auto && mode.src_host && !run_q;

  boot_byte_loader #(
    .BOOT_WORDS(BOOT_WORDS), .PM_AW(PM_AW), .PM_DW(PM_DW), .BM_AW(BM_AW)
  ) u_bytes (
    .clk_i, .rst_ni, .en_i(byte_en),
    .bm_req_o, .bm_addr_o, .bm_rdata_i,
    .pm_we_o, .pm_addr_o, .pm_wdata_o, .last_o(byte_last)
  );

  boot_host_watch #(.PM_AW(PM_AW)) u_host (
    .en_i(host_en), .host_we_i, .host_addr_i, .release_o(host_rel)
  );

  always_comb begin
    release_c = 1'b0;
    if (active && !run_q) begin
      if (mode.no_auto)       release_c = 1'b1;
      else if (mode.src_host) release_c = host_rel;
      else                    release_c = byte_last;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        run_q <= 1'b0;
    else if (release_c) run_q <= 1'b1;
  end

  assign boot_done_o = release_c;
  assign run_o       = run_q;
  assign mem_host_o  = mode.mem_host;
endmodule

// File: rtl/boot_seq_checker.sv
module boot_seq_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic run_o,
  input logic boot_done_o,
  input logic bm_req_o,
  input logic pm_we_o,
  input logic mem_host_o
);
  assert_run_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_o |=> run_o);
  assert_run_follows_done_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    boot_done_o |=> run_o);
  assert_done_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    boot_done_o |=> !boot_done_o);
  assert_no_early_run_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_o) |-> $past(boot_done_o));
  assert_mode_frozen_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(rst_ni, 2)) |-> $stable(mem_host_o));
  assert_bm_idle_after_run_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_o |-> !bm_req_o);
  assert_pm_idle_after_run_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_o |-> !pm_we_o);
endmodule

bind boot_seq_top boot_seq_checker u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .run_o(run_o), .boot_done_o(boot_done_o),
  .bm_req_o(bm_req_o), .pm_we_o(pm_we_o), .mem_host_o(mem_host_o)
);

// File: tb/boot_seq_top_tb.sv
`timescale 1ns/1ps
module boot_seq_top_tb;
  localparam int W     = 32;
  localparam int PM_AW = 14;
  localparam int PM_DW = 24;
  localparam int BM_AW = 16;
  localparam int NCYC  = 110;

  logic clk = 1'b0, rst_n = 1'b0;
  logic s_mem = 1'b0, s_nob = 1'b0, s_src = 1'b0;
  logic bm_req, pm_we, host_we = 1'b0, mem_host, done, run;
  logic [BM_AW-1:0] bm_addr;
  logic [7:0]       bm_rdata = 8'h00;
  logic [PM_AW-1:0] pm_addr, host_addr = '0;
  logic [PM_DW-1:0] pm_wdata;
  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  boot_seq_top #(.BOOT_WORDS(W), .PM_AW(PM_AW), .PM_DW(PM_DW), .BM_AW(BM_AW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .strap_mem_i(s_mem), .strap_noboot_i(s_nob),
    .strap_src_i(s_src), .bm_req_o(bm_req), .bm_addr_o(bm_addr), .bm_rdata_i(bm_rdata),
    .pm_we_o(pm_we), .pm_addr_o(pm_addr), .pm_wdata_o(pm_wdata), .host_we_i(host_we),
    .host_addr_i(host_addr), .mem_host_o(mem_host), .boot_done_o(done), .run_o(run)
  );

  function automatic logic [7:0] bval(int a);
    return 8'((a * 37 + 11) & 255);
  endfunction

  always @(posedge clk) if (bm_req) bm_rdata <= bval(int'(bm_addr));

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  initial begin
    #(200000 * 8);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int m = 0; m < 8; m++) begin
      logic cb, bb, ab, is_byte, is_host;
      cb = m[2]; bb = m[1]; ab = m[0];
      is_byte = !bb && !ab;
      is_host = !bb && ab;
      @(negedge clk);
      rst_n = 1'b0; s_mem = cb; s_nob = bb; s_src = ab; host_we = 1'b0;
      #1;
      chk(run == 1'b0, "R3", "run in reset", run, 0);
      repeat (3) @(negedge clk);
      chk(run == 1'b0 && done == 1'b0, "R3", "run/done in reset", {run, done}, 0);
      rst_n = 1'b1;
      for (int c = 0; c < NCYC; c++) begin
        logic exp_req, exp_we, exp_done, exp_run;
        int w;
        @(posedge clk); #1;
        if (c == 0) begin s_mem = ~cb; s_nob = ~bb; s_src = ~ab; end
        host_we   = (c == 10 || c == 20 || c == 45);
        host_addr = (c == 10) ? PM_AW'(5) : '0;
        @(negedge clk);
        exp_req  = is_byte && c < 3 * W;
        exp_we   = is_byte && c >= 4 && ((c - 1) % 3 == 0) && c <= 3 * W + 1;
        exp_done = is_byte ? (c == 3 * W + 1) : is_host ? (c == 20) : (c == 0);
        exp_run  = is_byte ? (c > 3 * W + 1) : is_host ? (c > 20) : (c > 0);
        chk(mem_host == cb, "R1 R2", "mem_host", mem_host, cb);
        chk(done == exp_done, is_byte ? "R6" : is_host ? "R7" : "R8", "boot_done", done, exp_done);
        chk(run == exp_run, "R3 R9", "run", run, exp_run);
        chk(bm_req == exp_req, is_byte ? "R4" : "R10", "bm_req", bm_req, exp_req);
        if (exp_req) chk(bm_addr == BM_AW'(c), "R4", "bm_addr", bm_addr, c);
        chk(pm_we == exp_we, is_byte ? "R5" : "R8", "pm_we", pm_we, exp_we);
        if (exp_we) begin
          w = (c - 1) / 3 - 1;
          chk(pm_addr == PM_AW'(w), "R5", "pm_addr", pm_addr, w);
          chk(pm_wdata == {bval(3 * w), bval(3 * w + 1), bval(3 * w + 2)}, "R5", "pm_wdata",
              pm_wdata, {bval(3 * w), bval(3 * w + 1), bval(3 * w + 2)});
        end
      end
      host_we = 1'b0;
    end
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(run == 1'b0, "R3", "run after re-reset", run, 0);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule